// File: doc/BRIEF.md
# Line-Port Scanning Multiplexer

This block is the first stage of a receive path that shares one processing pipeline among many line ports. Each line port delivers 9-byte words into its own receive FIFO. The multiplexer serves exactly one port per clock cycle and places that port's word on a single 72-bit output stream. Each output word carries the index of the port it came from. Downstream units can therefore switch context from word to word. The system clock must run faster than the sum of all port word rates, so the scan always drains a FIFO before the FIFO can overflow.

Which port is served in a given cycle comes from a slot table of 64 entries, each holding a 6-bit port index. A port running N times the base rate appears in N entries spread evenly over the table. One STM-64 port, four STM-16 ports, sixteen STM-4 ports, sixty-four STM-1 ports, or any mix that fills the 64 slots can all share the stream. Sometimes the scheduled port has no new word. In that case the block repeats the last word it took from that port and raises a duplicate flag, so later stages discard the word. A new table is applied with a one-cycle load strobe, and scanning then restarts at slot 0.

Top module: `lineport_scan_mux`

## Requirements
- R1: While `rst_n` is low, every output is 0 and no FIFO read strobe is raised.
- R2: Each served cycle advances the slot pointer by one, wrapping from slot 63 to slot 0. The port served is the table entry at the current slot, and `out_port` carries that index.
- R3: When the scheduled port's FIFO is not empty, exactly that port's `fifo_rd` bit is high in the same cycle. Its word is emitted with `out_dup` = 0.
- R4: When the scheduled port's FIFO is empty, no read strobe is raised. The block emits the last word previously taken from that port, with `out_dup` = 1. A port never read since reset yields an all-zero word.
- R5: Each served word appears on the outputs, with `out_valid` = 1, one clock cycle after the cycle in which its slot was active.
- R6: `out_sof` is 1 exactly on words served from slot 0.
- R7: In a cycle with `cfg_load` high, the table is replaced by `cfg_table` and no read strobe is raised. The next cycle shows `out_valid` = 0. Scanning then resumes at slot 0 of the new table.
- R8: After reset, the table maps slot s to port s mod 64, which is 64 equal-rate ports. Slot s's index sits in `cfg_table` bits [6s+5:6s].
- R9: The last-word store of one port is changed only by a read from that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Apply `cfg_table` and restart at slot 0 |
| cfg_table | input | 384 | Slot table, 6-bit port index per slot, slot 0 in the low bits |
| fifo_empty | input | 64 | Per-port FIFO empty flags, bit p for port p |
| fifo_data | input | 4608 | Per-port FIFO head word, port p at bits [72p+71:72p] |
| fifo_rd | output | 64 | Per-port FIFO pop strobe, one-hot or zero |
| out_valid | output | 1 | A slot was served in the previous cycle |
| out_port | output | 6 | Port index of the output word |
| out_data | output | 72 | 9-byte output word |
| out_dup | output | 1 | Word is a repeat and must be ignored |
| out_sof | output | 1 | Word comes from slot 0 |

## Verification
The read strobe depends combinationally on the current slot, the table and the empty flags. It is therefore due in the same cycle as the stimulus, and the bench samples it one time step after driving inputs on the falling edge. The output word, port, duplicate flag, start flag and the gap after a load all pass through a single register stage. The bench keeps the expectation it formed for one cycle and compares it at the next falling edge, one full cycle later. The reset values are checked while reset is held, so they do not wait for a clock edge.

// File: rtl/lineport_scan_pkg.sv
package lineport_scan_pkg;

    localparam int unsigned WORD_BYTES = 9;
    localparam int unsigned WORD_W     = WORD_BYTES * 8;
    localparam int unsigned PORT_W     = 6;

    typedef logic [WORD_W-1:0] scan_word_t;
    typedef logic [PORT_W-1:0] port_idx_t;

    typedef struct packed {
        logic       valid;
        logic       dup;
        logic       sof;
        port_idx_t  port;
        scan_word_t data;
    } scan_beat_t;

endpackage

// File: rtl/lineport_scan_sched.sv
module lineport_scan_sched
    import lineport_scan_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 64,
    parameter int unsigned NUM_SLOTS = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_load,
    input  logic [NUM_SLOTS*PORT_W-1:0] cfg_table,
    output logic                        serve,
    output port_idx_t                   cur_port,
    output logic                        cur_first
);

    localparam int unsigned SLOT_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int unsigned TABLE_W = NUM_SLOTS * PORT_W;

    typedef struct packed {
        logic [TABLE_W-1:0] tbl;
        logic [SLOT_W-1:0]  slot;
    } sched_st_t;

    sched_st_t st_d, st_q;

    function automatic logic [TABLE_W-1:0] boot_table();
        logic [TABLE_W-1:0] t;
        t = '0;
        for (int s = 0; s < int'(NUM_SLOTS); s++) begin
            t[s*PORT_W +: PORT_W] = PORT_W'(s % int'(NUM_PORTS));
        end
        return t;
    endfunction

    assign serve     = rst_n && !cfg_load;
    assign cur_port  = st_q.tbl[int'(st_q.slot)*PORT_W +: PORT_W];
    assign cur_first = (st_q.slot == '0);

    always_comb begin
        st_d = st_q;
        if (cfg_load) begin
            st_d.tbl  = cfg_table;
            st_d.slot = '0;
        end else if (st_q.slot == SLOT_W'(NUM_SLOTS - 1)) begin
            st_d.slot = '0;
        end else begin
            st_d.slot = st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tbl  <= boot_table();
            st_q.slot <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load && st_q.slot == SLOT_W'(NUM_SLOTS - 1)) |=> cur_first); // R2

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> cur_first); // R7

endmodule

// File: rtl/lineport_scan_select.sv
module lineport_scan_select
    import lineport_scan_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 64
) (
    input  logic                        serve,
    input  port_idx_t                   port,
    input  logic [NUM_PORTS-1:0]        fifo_empty,
    input  logic [NUM_PORTS*WORD_W-1:0] fifo_data,
    output logic [NUM_PORTS-1:0]        fifo_rd,
    output logic                        sel_empty,
    output scan_word_t                  sel_data
);

    logic in_range;
    int   port_i;

    assign port_i   = int'(port);
    assign in_range = (port_i < int'(NUM_PORTS));

    for (genvar p = 0; p < int'(NUM_PORTS); p++) begin : g_rd
        assign fifo_rd[p] = serve && (port_i == p) && !fifo_empty[p];
    end

    always_comb begin
        sel_empty = 1'b1;
        sel_data  = '0;
        if (in_range) begin
            sel_empty = fifo_empty[port_i];
            sel_data  = fifo_data[port_i*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/lineport_scan_hold.sv
module lineport_scan_hold
    import lineport_scan_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  port_idx_t  idx,
    input  scan_word_t wr_word,
    output scan_word_t rd_word
);

    scan_word_t [NUM_PORTS-1:0] bank_d, bank_q;
    logic in_range;

    assign in_range = (int'(idx) < int'(NUM_PORTS));
    assign rd_word  = in_range ? bank_q[int'(idx)] : '0;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && in_range) begin
            bank_d[int'(idx)] = wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (bank_q == $past(bank_q))); // R9

endmodule

// File: rtl/lineport_scan_mux.sv
module lineport_scan_mux
    import lineport_scan_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 64,
    parameter int unsigned NUM_SLOTS = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_load,
    input  logic [NUM_SLOTS*PORT_W-1:0] cfg_table,
    input  logic [NUM_PORTS-1:0]        fifo_empty,
    input  logic [NUM_PORTS*WORD_W-1:0] fifo_data,
    output logic [NUM_PORTS-1:0]        fifo_rd,
    output logic                        out_valid,
    output logic [PORT_W-1:0]           out_port,
    output logic [WORD_W-1:0]           out_data,
    output logic                        out_dup,
    output logic                        out_sof
);

    logic       serve;
    port_idx_t  cur_port;
    logic       cur_first;
    logic       sel_empty;
    scan_word_t sel_data;
    scan_word_t hold_word;
    logic       hold_we;

    scan_beat_t beat_d, beat_q;

    lineport_scan_sched #(
        .NUM_PORTS (NUM_PORTS),
        .NUM_SLOTS (NUM_SLOTS)
    ) sched_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .cfg_table (cfg_table),
        .serve     (serve),
        .cur_port  (cur_port),
        .cur_first (cur_first)
    );

    lineport_scan_select #(
        .NUM_PORTS (NUM_PORTS)
    ) select_i (
        .serve      (serve),
        .port       (cur_port),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .fifo_rd    (fifo_rd),
        .sel_empty  (sel_empty),
        .sel_data   (sel_data)
    );

    assign hold_we = serve && !sel_empty;

    lineport_scan_hold #(
        .NUM_PORTS (NUM_PORTS)
    ) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hold_we),
        .idx     (cur_port),
        .wr_word (sel_data),
        .rd_word (hold_word)
    );

    always_comb begin
        beat_d = beat_q;
        if (serve) begin
            beat_d.valid = 1'b1;
            beat_d.port  = cur_port;
            beat_d.sof   = cur_first;
            beat_d.dup   = sel_empty;
            beat_d.data  = sel_empty ? hold_word : sel_data;
        end else begin
            beat_d.valid = 1'b0;
            beat_d.dup   = 1'b0;
            beat_d.sof   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign out_valid = beat_q.valid;
    assign out_port  = beat_q.port;
    assign out_data  = beat_q.data;
    assign out_dup   = beat_q.dup;
    assign out_sof   = beat_q.sof;

    AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_rd)); // R3

    AST_LOAD_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |-> (fifo_rd == '0)); // R7

    AST_LOAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> !out_valid); // R7

    AST_DUP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dup) |-> ($past(fifo_rd) == '0)); // R4

    AST_FRESH_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_dup) |-> ($past(fifo_rd) != '0)); // R3

    AST_PORT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_port == $past(cur_port))); // R5

    AST_RESTART_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(out_valid)) |-> out_sof); // R6

endmodule

// File: tb/lineport_scan_mux_tb_top.sv
module lineport_scan_mux_tb_top;
    import lineport_scan_pkg::*;

    localparam int NP = 64;
    localparam int NS = 64;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   cfg_load = 1'b0;
    logic [NS*PORT_W-1:0]   cfg_table = '0;
    logic [NP-1:0]          fifo_empty = '1;
    logic [NP*WORD_W-1:0]   fifo_data = '0;
    logic [NP-1:0]          fifo_rd;
    logic                   out_valid;
    logic [PORT_W-1:0]      out_port;
    logic [WORD_W-1:0]      out_data;
    logic                   out_dup;
    logic                   out_sof;

    always #4 clk = ~clk;

    lineport_scan_mux #(.NUM_PORTS(NP), .NUM_SLOTS(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_table(cfg_table),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
        .out_valid(out_valid), .out_port(out_port), .out_data(out_data),
        .out_dup(out_dup), .out_sof(out_sof)
    );

    int n_tests = 0;
    int n_fail  = 0;

    int         m_table [NS];
    int         m_slot;
    scan_word_t m_hold  [NP];
    int         m_cnt   [NP];
    int         gcyc = 0;
    logic       have_exp = 1'b0;
    logic       e_valid, e_dup, e_sof;
    int         e_port;
    scan_word_t e_data;

    function automatic logic [15:0] mkv(int load, int kind, int pat, int cyc);
        return {1'b0, 1'(load), 3'(kind), 3'(pat), 8'(cyc)};
    endfunction

    // load flag, table kind, empty pattern, cycles to run
    localparam logic [15:0] VECS [7] = '{
        mkv(0, 0, 0, 70),
        mkv(1, 1, 1, 40),
        mkv(1, 4, 2, 130),
        mkv(1, 3, 3, 10),
        mkv(1, 3, 0, 5),
        mkv(1, 2, 2, 20),
        mkv(1, 4, 0, 70)
    };

    task automatic check(string req, string what, logic [127:0] act, logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // kind 0: 64 equal ports; 1: 16 ports x4; 2: 4 ports x16; 3: one port x64;
    // 4: ports 0,1 x16, ports 2..5 x4, ports 6..21 x1
    function automatic int tbl_port(int kind, int s);
        case (kind)
            0: return s % NP;
            1: return s % 16;
            2: return s % 4;
            3: return 0;
            default: begin
                case (s % 4)
                    0: return 0;
                    1: return 1;
                    2: return 2 + ((s / 4) % 4);
                    default: return 6 + (s / 4);
                endcase
            end
        endcase
    endfunction

    function automatic logic is_empty(int pat, int p, int cyc);
        case (pat)
            0: return 1'b0;
            1: return p[0];
            2: return ((cyc + p) % 3) == 0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic scan_word_t mk_data(int p, int cyc, int cnt);
        return {8'(p), 32'(cyc), 32'(cnt)};
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NS; s++) m_table[s] = s % NP;   // R8 boot table
        for (int p = 0; p < NP; p++) m_hold[p] = '0;
        m_slot   = 0;
        have_exp = 1'b0;
    endtask

    task automatic cycle(logic load, int kind, int pat);
        logic [NP-1:0] exp_rd;
        int p;
        if (have_exp) begin
            if (!e_valid) begin
                check("R7", "gap after load", 128'(out_valid), 128'(0));
            end else begin
                check("R5", "valid", 128'(out_valid), 128'(1));
                check("R2", "port", 128'(out_port), 128'(e_port));
                check("R6", "sof", 128'(out_sof), 128'(e_sof));
                if (e_dup) begin
                    check("R4", "dup", 128'(out_dup), 128'(1));
                    check("R4", "stale data", 128'(out_data), 128'(e_data));
                end else begin
                    check("R3", "dup", 128'(out_dup), 128'(0));
                    check("R3", "data", 128'(out_data), 128'(e_data));
                end
            end
        end
        for (int q = 0; q < NP; q++) begin
            fifo_empty[q] = is_empty(pat, q, gcyc);
            fifo_data[q*WORD_W +: WORD_W] = mk_data(q, gcyc, m_cnt[q]);
        end
        cfg_load = load;
        if (load) begin
            for (int s = 0; s < NS; s++) cfg_table[s*PORT_W +: PORT_W] = PORT_W'(tbl_port(kind, s));
        end
        #1;
        exp_rd = '0;
        if (!load) begin
            p = m_table[m_slot];
            if (!fifo_empty[p]) exp_rd[p] = 1'b1;
        end
        check(load ? "R7" : "R3", "read strobe", 128'(fifo_rd), 128'(exp_rd));
        if (load) begin
            e_valid = 1'b0;
            m_slot  = 0;
            for (int s = 0; s < NS; s++) m_table[s] = tbl_port(kind, s);
        end else begin
            p       = m_table[m_slot];
            e_valid = 1'b1;
            e_port  = p;
            e_sof   = (m_slot == 0);
            if (fifo_empty[p]) begin
                e_dup  = 1'b1;
                e_data = m_hold[p];
            end else begin
                e_dup     = 1'b0;
                e_data    = mk_data(p, gcyc, m_cnt[p]);
                m_hold[p] = e_data;          // R9 only the read port changes
                m_cnt[p]++;
            end
            m_slot = (m_slot + 1) % NS;
        end
        have_exp = 1'b1;
        gcyc++;
        @(negedge clk);
    endtask

    task automatic check_reset_state();
        check("R1", "valid in reset", 128'(out_valid), 128'(0));
        check("R1", "port in reset", 128'(out_port), 128'(0));
        check("R1", "data in reset", 128'(out_data), 128'(0));
        check("R1", "dup/sof in reset", 128'({out_dup, out_sof}), 128'(0));
        check("R1", "read in reset", 128'(fifo_rd), 128'(0));
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) m_cnt[p] = 0;
        fifo_empty = '0;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        model_reset();

        // vector walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int v = 0; v < 7; v++) begin
            logic [15:0] vec;
            vec = VECS[v];
            if (vec[14]) cycle(1'b1, int'(vec[13:11]), int'(vec[10:8]));
            for (int c = 0; c < int'(vec[7:0]); c++) cycle(1'b0, int'(vec[13:11]), int'(vec[10:8]));
        end

        // R7: reload in the middle of a round restarts at slot 0
        cycle(1'b1, 1, 0);
        for (int c = 0; c < 10; c++) cycle(1'b0, 1, 0);
        cycle(1'b1, 1, 0);
        for (int c = 0; c < 4; c++) cycle(1'b0, 1, 0);

        // R7: two loads back to back give two idle output cycles
        cycle(1'b1, 4, 1);
        cycle(1'b1, 4, 1);
        for (int c = 0; c < 6; c++) cycle(1'b0, 4, 1);

        // R1, R8, R4: reset mid-run restores the boot table and clears stored words
        rst_n = 1'b0;
        cfg_load = 1'b0;
        fifo_empty = '0;
        #1;
        check("R1", "read during reset", 128'(fifo_rd), 128'(0));
        @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        model_reset();
        for (int c = 0; c < 66; c++) cycle(1'b0, 0, 1);
        cycle(1'b0, 0, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule